// File: doc/BRIEF.md
# Memory Access Wait-State Inserter

This block watches the processor's memory access strobe and, in fast clock mode, asks the processor clocking logic to stretch execution by one extra clock once enough accesses have built up. The number of accesses per extra clock is the wait factor. It is chosen every cycle from three configuration bits: the memory-mapping unit enable, the text-window enable and the fast-mapping mode bit. When the processor runs in slow clock mode, no extra clocks are requested and the access count is frozen.

The three factor values are parameters. The base factor applies when no special mode is active. The fast factor applies when the fast-mapping bit is set. The window factor applies when the mapping unit and the window are both enabled, and it takes priority over the fast factor. A factor of zero turns request generation off. The request is a registered single-cycle pulse, and the access counter clears whenever a request is issued. The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `mem_wait_inserter`

## Requirements
- R1: While reset is active and after its release, extra_clk is low and the access count is zero, so the first request follows exactly factor accesses.
- R2: With fast_clk low, extra_clk stays low and strobes do not change the stored access count.
- R3: With fast_clk high and none of the mode conditions below active, one request is issued every BASE_FACTOR strobes.
- R4: With map_fast high, and map_en and win_en not both high, the factor is FAST_FACTOR.
- R5: With map_en and win_en both high, the factor is WIN_FACTOR, whatever map_fast is.
- R6: map_en alone or win_en alone leaves the factor selection unchanged.
- R7: extra_clk rises in the cycle after the strobe that brings the count up to the factor. It stays high for one cycle only, unless that next cycle also completes a count. The count returns to zero when the request is issued.
- R8: A selected factor of zero produces no request, however many strobes arrive.
- R9: Cycles without a strobe neither change the count nor produce a request.
- R10: The count is compared with the factor selected in the current cycle, so a request fires as soon as the count plus one reaches or exceeds a newly selected, smaller factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| acc_stb | input | 1 | One memory access in this cycle |
| fast_clk | input | 1 | 1 = fast clock mode, 0 = slow clock mode (no waits) |
| map_en | input | 1 | Memory-mapping unit enabled |
| win_en | input | 1 | Text window enabled |
| map_fast | input | 1 | Fast-mapping mode bit |
| extra_clk | output | 1 | Single-cycle request for one extra processor clock |

## Verification
The main instance is built with base, fast and window factors of 4, 2 and 3. Because these three values differ, each selection path gives its own pulse spacing, and the priority of the window factor over the fast factor shows up directly in the pulse count. A second instance is built with factors 0, 1 and 0. It shows that a zero factor never issues a request, and that a factor of one issues a request on every strobe, including back-to-back pulses.

// File: rtl/mem_wait_pkg.sv
package mem_wait_pkg;
  typedef enum logic [1:0] {
    FSRC_BASE = 2'd0,
    FSRC_FAST = 2'd1,
    FSRC_WIN  = 2'd2
  } fsrc_e;
endpackage

// File: rtl/mem_wait_rst_sync.sv
module mem_wait_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q[g] <= 1'b0;
        end else begin
          if (g == 0) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign rst_s = sync_q[STAGES-1];
endmodule

// File: rtl/mem_wait_factor_sel.sv
module mem_wait_factor_sel
  import mem_wait_pkg::*;
#(
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned BASE_FACTOR = 3,
  parameter int unsigned FAST_FACTOR = 2,
  parameter int unsigned WIN_FACTOR  = 2
) (
  input  logic             map_en,
  input  logic             win_en,
  input  logic             map_fast,
  output logic [CNT_W-1:0] factor
);
  localparam logic [CNT_W-1:0] BASE_V = CNT_W'(BASE_FACTOR);
  localparam logic [CNT_W-1:0] FAST_V = CNT_W'(FAST_FACTOR);
  localparam logic [CNT_W-1:0] WIN_V  = CNT_W'(WIN_FACTOR);

  fsrc_e src;

  // Window with mapping unit has the last word, then fast mapping.
  always_comb begin
    src = FSRC_BASE;
    if (map_fast)          src = FSRC_FAST;
    if (map_en && win_en)  src = FSRC_WIN;
  end

  always_comb begin
    unique case (src)
      FSRC_FAST: factor = FAST_V;
      FSRC_WIN:  factor = WIN_V;
      default:   factor = BASE_V;
    endcase
  end
endmodule

// File: rtl/mem_wait_counter.sv
module mem_wait_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_s,
  input  logic             acc_stb,
  input  logic             fast_clk,
  input  logic [CNT_W-1:0] factor,
  output logic [CNT_W-1:0] cnt_q,
  output logic             extra_q
);
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             fire;
  logic             active;

  always_comb begin
    active  = acc_stb && fast_clk && (factor != '0);
    cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    fire    = active && (cnt_inc >= {1'b0, factor});
    cnt_en  = active;
    cnt_d   = fire ? '0 : cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      extra_q <= 1'b0;
    end else begin
      extra_q <= fire;
    end
  end
endmodule

// File: rtl/mem_wait_inserter.sv
module mem_wait_inserter #(
  parameter int unsigned MAX_FACTOR  = 15,
  parameter int unsigned BASE_FACTOR = 3,
  parameter int unsigned FAST_FACTOR = 2,
  parameter int unsigned WIN_FACTOR  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_stb,
  input  logic fast_clk,
  input  logic map_en,
  input  logic win_en,
  input  logic map_fast,
  output logic extra_clk
);
  localparam int unsigned CNT_W = $clog2(MAX_FACTOR + 1);

  logic             rst_s;
  logic [CNT_W-1:0] factor_w;
  logic [CNT_W-1:0] cnt_q;

  mem_wait_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  mem_wait_factor_sel #(
    .CNT_W       (CNT_W),
    .BASE_FACTOR (BASE_FACTOR),
    .FAST_FACTOR (FAST_FACTOR),
    .WIN_FACTOR  (WIN_FACTOR)
  ) u_sel (
    .map_en   (map_en),
    .win_en   (win_en),
    .map_fast (map_fast),
    .factor   (factor_w)
  );

  mem_wait_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_s    (rst_s),
    .acc_stb  (acc_stb),
    .fast_clk (fast_clk),
    .factor   (factor_w),
    .cnt_q    (cnt_q),
    .extra_q  (extra_clk)
  );
endmodule

// File: rtl/mem_wait_inserter_chk.sv
module mem_wait_inserter_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_s,
  input logic             acc_stb,
  input logic             fast_clk,
  input logic             extra_clk,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] factor_w
);
  // R2
  slow_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !fast_clk |=> !extra_clk);

  // R9
  idle_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !acc_stb |=> !extra_clk);

  // R8
  zero_factor_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (factor_w == '0) |=> !extra_clk);

  // R7
  clear_on_req_chk: assert property (@(posedge clk) disable iff (!rst_s)
    extra_clk |-> (cnt_q == '0));

  // R7
  req_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_s)
    extra_clk |-> $past(acc_stb && fast_clk));

  // R2
  slow_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!fast_clk && !extra_clk) |=> $stable(cnt_q));
endmodule

bind mem_wait_inserter mem_wait_inserter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .acc_stb   (acc_stb),
  .fast_clk  (fast_clk),
  .extra_clk (extra_clk),
  .cnt_q     (cnt_q),
  .factor_w  (factor_w)
);

// File: tb/tb_mem_wait_inserter.sv
module tb_mem_wait_inserter;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // row: [15] fast_clk, [14] map_en, [13] win_en, [12] map_fast, [11:6] strobes, [5:0] expected pulses
  // main instance factors: base 4, fast 2, window 3
  localparam logic [15:0] VEC [NVEC] = '{
    {4'b1000, 6'd8,  6'd2},  // R3 base
    {4'b1001, 6'd7,  6'd3},  // R4 fast
    {4'b1110, 6'd9,  6'd3},  // R5 window
    {4'b1111, 6'd7,  6'd2},  // R5 window over fast
    {4'b1100, 6'd8,  6'd2},  // R6 map only
    {4'b1010, 6'd8,  6'd2},  // R6 window only
    {4'b0111, 6'd10, 6'd0},  // R2 slow
    {4'b1011, 6'd6,  6'd3}   // R6 window only with fast -> fast
  };

  logic clk = 1'b0;
  logic rst_n, acc_stb, fast_clk, map_en, win_en, map_fast;
  logic extra_clk, z_extra;
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_wait_inserter #(.BASE_FACTOR(4), .FAST_FACTOR(2), .WIN_FACTOR(3)) dut (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .fast_clk(fast_clk),
    .map_en(map_en), .win_en(win_en), .map_fast(map_fast), .extra_clk(extra_clk)
  );

  mem_wait_inserter #(.BASE_FACTOR(0), .FAST_FACTOR(1), .WIN_FACTOR(0)) dut_z (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .fast_clk(fast_clk),
    .map_en(map_en), .win_en(win_en), .map_fast(map_fast), .extra_clk(z_extra)
  );

  function automatic string row_tag(input int i);
    case (i)
      0: return "R3";
      1: return "R4";
      2, 3: return "R5";
      6: return "R2";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic f, input logic m, input logic w, input logic mf);
    fast_clk = f; map_en = m; win_en = w; map_fast = mf;
  endtask

  // drive at negedge, sample at the following negedge
  task automatic cyc(input logic stb);
    acc_stb = stb;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    acc_stb = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int pulses;
    cfg(1'b1, 1'b0, 1'b0, 1'b0);
    acc_stb = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 extra low in reset", int'(extra_clk), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 extra low after reset", int'(extra_clk), 0);

    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      cfg(VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12]);
      pulses = 0;
      for (int k = 0; k < int'(VEC[i][11:6]); k++) begin
        cyc(1'b1);
        if (extra_clk) pulses++;
      end
      cyc(1'b0);
      check({row_tag(i), " pulse count"}, pulses, int'(VEC[i][5:0]));
      check({row_tag(i), " idle after"}, int'(extra_clk), 0);
    end

    // R1 / R7: exact position and width of the first pulse (base 4)
    do_reset();
    cfg(1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b1); cyc(1'b1); cyc(1'b1);
    check("R1 no pulse after 3 strobes", int'(extra_clk), 0);
    cyc(1'b1);
    check("R7 pulse after 4th strobe", int'(extra_clk), 1);
    cyc(1'b0);
    check("R7 pulse one cycle", int'(extra_clk), 0);
    cyc(1'b1); cyc(1'b1); cyc(1'b1);
    check("R7 count cleared, 3 more no pulse", int'(extra_clk), 0);
    cyc(1'b1);
    check("R7 next pulse after 4 more", int'(extra_clk), 1);

    // R9: idle cycles hold the count
    do_reset();
    cyc(1'b1);
    pulses = 0;
    for (int k = 0; k < 5; k++) begin
      cyc(1'b0);
      if (extra_clk) pulses++;
    end
    check("R9 no pulse while idle", pulses, 0);
    cyc(1'b1); cyc(1'b1);
    check("R9 no pulse at count 3", int'(extra_clk), 0);
    cyc(1'b1);
    check("R9 pulse at 4th strobe across gap", int'(extra_clk), 1);

    // R2: slow mode freezes the count
    do_reset();
    cyc(1'b1); cyc(1'b1);
    cfg(1'b0, 1'b0, 1'b0, 1'b0);
    pulses = 0;
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1);
      if (extra_clk) pulses++;
    end
    check("R2 no pulse in slow mode", pulses, 0);
    cfg(1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b1);
    check("R2 count held, no pulse at 3", int'(extra_clk), 0);
    cyc(1'b1);
    check("R2 pulse at 4 fast strobes", int'(extra_clk), 1);

    // R10: factor drops below stored count
    do_reset();
    cyc(1'b1); cyc(1'b1); cyc(1'b1);
    cfg(1'b1, 1'b0, 1'b0, 1'b1);
    cyc(1'b1);
    check("R10 pulse when factor lowered", int'(extra_clk), 1);

    // R8: zero factor instance, and factor one back to back
    do_reset();
    cfg(1'b1, 1'b0, 1'b0, 1'b0);
    pulses = 0;
    for (int k = 0; k < 6; k++) begin
      cyc(1'b1);
      if (z_extra) pulses++;
    end
    check("R8 zero base factor no pulse", pulses, 0);
    cfg(1'b1, 1'b1, 1'b1, 1'b1);
    pulses = 0;
    for (int k = 0; k < 6; k++) begin
      cyc(1'b1);
      if (z_extra) pulses++;
    end
    check("R8 zero window factor no pulse", pulses, 0);
    cfg(1'b1, 1'b0, 1'b0, 1'b1);
    pulses = 0;
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1);
      if (z_extra) pulses++;
    end
    check("R7 factor one pulses every strobe", pulses, 3);
    cyc(1'b0);
    check("R7 factor one ends after idle", int'(z_extra), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule